// File: doc/BRIEF.md
# System-to-Peripheral Bus Bridge

This block is the only slave the high-performance system bus sees for a whole group of low-power peripherals. A system transfer that selects the bridge is captured whole: address, direction, size and write data. The bridge then runs its own short access on the peripheral side, and finally answers the system master with read data and a wait, error and last response. The system master holds its select and transfer fields steady until the bridge drops wait.

The peripherals never see the pipelined system signals. They see an address, a direction bit and write data that the bridge latched. They also see one select line per peripheral, which comes from the bridge's own secondary decoder, and a one-cycle access strobe. A valid access takes one setup cycle with the select active, then one strobe cycle, then one response cycle. A transfer whose address decodes to no peripheral, or that uses the reserved size code, is answered with an error after a single cycle. No select or strobe is raised for it.

Top module: `sp_bridge`

## Requirements
- R1: While rst_ni is low and after its release, every peripheral select, the strobe, wait_o and error_o are low, provided sel_i is low.
- R2: For a valid access, wait_o is high from the cycle sel_i rises until the third rising clock edge after sel_i was first sampled high. After that edge wait_o is low for one response cycle.
- R3: The peripheral index is address bits [SLOT_AW+IDX_W-1:SLOT_AW] (bits 14:12 by default). Index k below N_PERIPH drives psel_o bit k alone, and at most one select bit is ever high.
- R4: paddr_o and pwrite_o hold the values captured from addr_i and write_i, and they stay unchanged for as long as a select is active.
- R5: Each valid access raises pstrobe_o for exactly one cycle, in the cycle after the select first rises. The strobe never rises without an active select.
- R6: pwrite_o is 1 for writes and 0 for reads. pwdata_o carries the captured wdata_i during a write and is all zeros during a read.
- R7: On a read, rdata_o in the response cycle equals the slice of prdata_i that belongs to the selected peripheral. Other peripherals' data is ignored, and rdata_o is zero outside the response cycle.
- R8: An index of N_PERIPH or above (5 to 7 by default) raises no select and no strobe. error_o is high in the response cycle, which comes one edge after capture, and rdata_o is zero.
- R9: Size codes 0 (byte), 1 (half-word) and 2 (word) are accepted. Code 3 is reserved and takes the R8 error path.
- R10: last_o is high in every response cycle, and only there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bridge selected by the system decoder |
| addr_i | input | ADDR_W | System address |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Transfer size code |
| wdata_i | input | DATA_W | System write data |
| rdata_o | output | DATA_W | Read data to the system bus |
| wait_o | output | 1 | Transfer needs further cycles |
| error_o | output | 1 | Transfer failed |
| last_o | output | 1 | Burst must end here |
| paddr_o | output | ADDR_W | Latched peripheral address |
| pwrite_o | output | 1 | Peripheral direction |
| pwdata_o | output | DATA_W | Peripheral write data |
| psel_o | output | N_PERIPH | One select per peripheral |
| pstrobe_o | output | 1 | One-cycle access strobe |
| prdata_i | input | N_PERIPH*DATA_W | Read data of all peripherals, peripheral k at slice k |

## Verification
The hardest case to reach from the ports is a series of transfers in which the bridge must not start again on the sel_i that the master is still holding while the response cycle ends. The stimulus therefore drops sel_i in the same half-cycle in which it sees wait_o low, and it issues reads to different peripherals back to back. Each of those peripherals drives its own distinct read word, so a stale capture or a wrong mux slice shows up. The error path is reached through unmapped indices at both ends of the hole and through the reserved size code used with an otherwise valid address.

// File: rtl/sp_bridge_pkg.sv
package sp_bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_RESP
  } br_state_e;
endpackage

// File: rtl/sp_periph_decode.sv
module sp_periph_decode #(
  parameter int IDX_W    = 3,
  parameter int N_PERIPH = 5
) (
  input  logic [IDX_W-1:0]    idx_i,
  output logic                hit_o,
  output logic [N_PERIPH-1:0] onehot_o
);
  for (genvar g = 0; g < N_PERIPH; g++) begin : g_sel
    assign onehot_o[g] = (idx_i == IDX_W'(g));
  end
  assign hit_o = |onehot_o;
endmodule

// File: rtl/sp_bridge_fsm.sv
module sp_bridge_fsm
  import sp_bridge_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sel_i,
  input  logic      bad_i,
  output br_state_e state_o
);
  br_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (sel_i) state_d = bad_i ? ST_RESP : ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_RESP;
      ST_RESP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;

  a_r2_resp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RESP |=> state_q == ST_IDLE);
endmodule

// File: rtl/sp_read_mux.sv
module sp_read_mux #(
  parameter int N_PERIPH = 5,
  parameter int DATA_W   = 32
) (
  input  logic [N_PERIPH*DATA_W-1:0] prdata_i,
  input  logic [N_PERIPH-1:0]        onehot_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [N_PERIPH:0][DATA_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar g = 0; g < N_PERIPH; g++) begin : g_or
    assign acc[g+1] = acc[g] | (prdata_i[g*DATA_W +: DATA_W] & {DATA_W{onehot_i[g]}});
  end
  assign rdata_o = acc[N_PERIPH];
endmodule

// File: rtl/sp_bridge.sv
module sp_bridge
  import sp_bridge_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 5,
  parameter int SLOT_AW  = 12,
  parameter int IDX_W    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       write_i,
  input  logic [1:0]                 size_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       wait_o,
  output logic                       error_o,
  output logic                       last_o,
  output logic [ADDR_W-1:0]          paddr_o,
  output logic                       pwrite_o,
  output logic [DATA_W-1:0]          pwdata_o,
  output logic [N_PERIPH-1:0]        psel_o,
  output logic                       pstrobe_o,
  input  logic [N_PERIPH*DATA_W-1:0] prdata_i
);
  br_state_e             state;
  logic                  hit, bad, capture;
  logic [N_PERIPH-1:0]   onehot_d, onehot_q;
  logic [ADDR_W-1:0]     addr_q;
  logic                  write_q, err_q;
  logic [DATA_W-1:0]     wdata_q, rdata_q, mux_data;

  sp_periph_decode #(.IDX_W(IDX_W), .N_PERIPH(N_PERIPH)) u_dec (
    .idx_i    (addr_i[SLOT_AW +: IDX_W]),
    .hit_o    (hit),
    .onehot_o (onehot_d)
  );

  assign bad     = !hit || (xfer_size_e'(size_i) == SZ_RSVD);
  assign capture = sel_i && (state == ST_IDLE);

  sp_bridge_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .bad_i   (bad),
    .state_o (state)
  );

  sp_read_mux #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) u_mux (
    .prdata_i (prdata_i),
    .onehot_i (onehot_q),
    .rdata_o  (mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      onehot_q <= '0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else if (capture) begin
      addr_q   <= addr_i;
      write_q  <= write_i;
      wdata_q  <= wdata_i;
      onehot_q <= bad ? '0 : onehot_d;
      err_q    <= bad;
      rdata_q  <= '0;
    end else if (state == ST_ACCESS && !write_q) begin
      rdata_q  <= mux_data;  // sample at end of strobe cycle
    end
  end

  assign psel_o    = (state == ST_SETUP || state == ST_ACCESS) ? onehot_q : '0;
  assign pstrobe_o = (state == ST_ACCESS);
  assign paddr_o   = addr_q;
  assign pwrite_o  = write_q;
  assign pwdata_o  = write_q ? wdata_q : '0;
  assign wait_o    = sel_i && (state != ST_RESP);
  assign last_o    = (state == ST_RESP);
  assign error_o   = (state == ST_RESP) && err_q;
  assign rdata_o   = (state == ST_RESP) ? rdata_q : '0;

  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(psel_o));
  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstrobe_o |=> !pstrobe_o);
  a_r5_strobe_has_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstrobe_o |-> psel_o != '0);
  a_r4_hold_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o != '0 && !pstrobe_o) |=> $stable(paddr_o) && $stable(pwrite_o));
  a_r6_no_wdata_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrite_o |-> pwdata_o == '0);
  a_r8_err_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (psel_o == '0 && !pstrobe_o));
  a_r10_last_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wait_o) |-> last_o);
endmodule

// File: tb/sp_bridge_bench.sv
module sp_bridge_bench;
  localparam int AW = 32, DW = 32, NP = 5;

  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wait_s, err, last;
  logic [AW-1:0] paddr;
  logic pwrite;
  logic [DW-1:0] pwdata;
  logic [NP-1:0] psel;
  logic pstrobe;
  logic [NP*DW-1:0] prdata;

  int total = 0, bad_n = 0;
  bit done = 0;

  // results of the last transfer
  int lat, strobes, unstable;
  logic [NP-1:0] sel_seen;
  logic [AW-1:0] paddr_seen;
  logic [DW-1:0] pwdata_seen, r_rdata;
  logic pwrite_seen, r_err, r_last;

  always #5 clk = ~clk;

  sp_bridge u_sp_bridge (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .write_i(wr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .wait_o(wait_s),
    .error_o(err), .last_o(last), .paddr_o(paddr), .pwrite_o(pwrite),
    .pwdata_o(pwdata), .psel_o(psel), .pstrobe_o(pstrobe), .prdata_i(prdata)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int idx, int off);
    return 32'h4000_0000 | (AW'(idx) << 12) | AW'(off);
  endfunction

  task automatic xfer(logic [AW-1:0] a, logic w, logic [1:0] sz, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr = w; size = sz; wdata = d; sel = 1;
    lat = 0; strobes = 0; unstable = 0; sel_seen = '0;
    paddr_seen = '0; pwdata_seen = '0; pwrite_seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (psel != '0) begin
        if (sel_seen != '0 && (paddr !== paddr_seen)) unstable++;
        sel_seen |= psel; paddr_seen = paddr; pwrite_seen = pwrite; pwdata_seen = pwdata;
      end
      if (pstrobe) strobes++;
      if (!wait_s) break;
    end
    r_rdata = rdata; r_err = err; r_last = last;
    sel = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 psel", psel, 0); chk("R1 strobe", pstrobe, 0);
    chk("R1 wait", wait_s, 0); chk("R1 error", err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 psel after", psel, 0); chk("R10 last idle", last, 0);
  endtask

  task automatic t_write(int idx, logic [1:0] sz, logic [DW-1:0] d);
    xfer(mk_addr(idx, 'h24), 1'b1, sz, d);
    chk("R2 latency", lat, 3);
    chk("R3 select", sel_seen, NP'(1) << idx);
    chk("R4 paddr", paddr_seen, mk_addr(idx, 'h24));
    chk("R4 stable", unstable, 0);
    chk("R5 strobes", strobes, 1);
    chk("R6 pwrite", pwrite_seen, 1);
    chk("R6 pwdata", pwdata_seen, d);
    chk("R9 size ok", r_err, 0);
    chk("R10 last", r_last, 1);
  endtask

  task automatic t_read(int idx);
    xfer(mk_addr(idx, 'h8), 1'b0, 2'd2, 32'hDEAD_BEEF);
    chk("R2 latency", lat, 3);
    chk("R3 select", sel_seen, NP'(1) << idx);
    chk("R6 pwrite rd", pwrite_seen, 0);
    chk("R6 pwdata rd", pwdata_seen, 0);
    chk("R7 rdata", r_rdata, prdata[idx*DW +: DW]);
    chk("R7 no error", r_err, 0);
    @(negedge clk);
    chk("R7 rdata idle", rdata, 0);
  endtask

  task automatic t_unmapped(int idx);
    xfer(mk_addr(idx, 0), 1'b0, 2'd2, '0);
    chk("R8 latency", lat, 1);
    chk("R8 no select", sel_seen, 0);
    chk("R8 no strobe", strobes, 0);
    chk("R8 error", r_err, 1);
    chk("R8 rdata", r_rdata, 0);
    chk("R10 last", r_last, 1);
  endtask

  task automatic t_reserved();
    xfer(mk_addr(1, 4), 1'b1, 2'd3, 32'h1234_5678);
    chk("R9 rsvd error", r_err, 1);
    chk("R9 rsvd latency", lat, 1);
    chk("R9 rsvd no strobe", strobes, 0);
    chk("R9 rsvd no select", sel_seen, 0);
  endtask

  initial begin
    for (int k = 0; k < NP; k++) prdata[k*DW +: DW] = 32'h5A00_0000 | (k << 8) | (k * 17);
    t_reset();
    t_write(2, 2'd2, 32'hCAFE_0002);
    t_write(0, 2'd0, 32'h0000_00A5);
    t_write(4, 2'd1, 32'h0000_BEEF);
    t_read(4);
    t_read(0);
    t_read(3);
    t_unmapped(5);
    t_unmapped(7);
    t_reserved();
    t_read(1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad_n++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end
endmodule